// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block keeps wall-clock time and calendar date as a set of BCD byte registers. The fields are seconds, minutes, hours, day of week, day of month, month and year, and bit 7 of the month register holds a century flag. A single-cycle clock enable, nominally at 32.768 kHz, drives an internal divider. When the divider wraps, all fields advance by one second together, with carries propagating from seconds up to the century flag.

Software sets any field through a byte-wide write port. Writing the seconds field also restarts the divider, so the next update comes one full second after that write. Other logic receives two outputs: a one-cycle pulse that coincides with each update, and a 1 Hz level that is low for the first half of each second and high for the second half.

The hours field has two encodings, 24-hour and 12-hour with an AM/PM flag. Month lengths are applied automatically, and February has 29 days in any year divisible by four.

Top module: `bcd_calendar_clock`

## Requirements
- R1: Seconds and minutes count in BCD from 00 to 59. Seconds wrap from 59 to 00 and carry into minutes, and minutes wrap from 59 to 00 and carry into hours.
- R2: When hours bit 6 is 0 (24-hour encoding), hours count 00 to 23 in BCD, with bit 5 acting as the tens digit 2. The step from 23:59:59 gives 00:00:00 and advances the date.
- R3: When hours bit 6 is 1 (12-hour encoding), bit 5 is the PM flag and bits 4:0 count 01 to 12 in BCD. The order is 11 AM, 12 PM, 1 PM and 11 PM, 12 AM, 1 AM. Only the step from 11:59:59 PM advances the date.
- R4: Day of week advances with the date at midnight and wraps from 7 to 1.
- R5: The date wraps to 01 and advances the month after the last day of each month. That day is 30 for months 04, 06, 09 and 11, and 31 for the other months except 02. For 02 it is 29 when the BCD year is divisible by four (00 included) and 28 otherwise.
- R6: Month wraps from 12 to 01 and advances the year. The year wraps from 99 to 00, and at that step the century flag (month bit 7) toggles.
- R7: All fields update only when the divider wraps, which takes DIV asserted `tick_32k` cycles. `tick_1hz` is high for exactly the one cycle in which the new values first appear. With no enables, nothing changes.
- R8: A write to address 0 (seconds) clears the divider. `sq_1hz` is then low, rises after DIV/2 enables, and the next update comes after DIV enables counted from the write.
- R9: Writes use addresses 0 to 6 for seconds, minutes, hours, day of week, date, month and year, and store the byte as given. A write overrides an update of the same field in the same cycle, and the other fields still update.
- R10: Reset gives 00:00:00 in 24-hour encoding, day 1, date 01, month 01 with century flag 0, year 00, and `tick_1hz` and `sq_1hz` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_32k | input | 1 | Oscillator clock enable, one cycle per oscillator period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Field select for a write |
| wr_data | input | 8 | Byte to store |
| sec | output | 8 | Seconds, BCD |
| min | output | 8 | Minutes, BCD |
| hour | output | 8 | Hours with encoding select and AM/PM or 20-hour bit |
| dow | output | 8 | Day of week, 1 to 7 |
| date | output | 8 | Day of month, BCD |
| month | output | 8 | Month, BCD, with century flag in bit 7 |
| year | output | 8 | Year, BCD |
| tick_1hz | output | 1 | One-cycle pulse marking each update |
| sq_1hz | output | 1 | 1 Hz level with 50% duty |

## Verification
A software write can land in the same cycle as the one-second update. The bench provokes this by asserting a minutes write together with the enable that wraps the divider. The expected result is that seconds roll over while minutes take the written byte, and `tick_1hz` still pulses. A related race, a seconds write arriving in a cycle where the divider could wrap, is covered by a property: in the cycle after a seconds write, no tick appears and the square wave is low.

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock #(
  parameter int DIV = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_32k,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic [7:0] sec,
  output logic [7:0] min,
  output logic [7:0] hour,
  output logic [7:0] dow,
  output logic [7:0] date,
  output logic [7:0] month,
  output logic [7:0] year,
  output logic       tick_1hz,
  output logic       sq_1hz
);
  localparam int CW = $clog2(DIV);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);
  localparam logic [CW-1:0] HALF = CW'(DIV / 2);

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  logic [CW-1:0] cnt;
  logic [7:0]    hour_nx, last_day;
  logic          day_wrap;

  wire sec_wr   = wr_en && (wr_addr == 3'd0);
  wire step     = tick_32k && (cnt == LAST) && !sec_wr;
  wire c_min    = (sec == 8'h59);
  wire c_hour   = c_min && (min == 8'h59);
  wire c_day    = c_hour && day_wrap;
  wire c_month  = c_day && (date == last_day);
  wire c_year   = c_month && (month[4:0] == 5'h12);
  wire [3:0] lsum = year[3:0] + {2'b00, year[4], 1'b0};
  wire leap     = (lsum[1:0] == 2'b00);

  assign sq_1hz = (cnt >= HALF);

  always_comb begin
    hour_nx  = bcd_inc(hour);
    day_wrap = 1'b0;
    if (hour[6]) begin
      if (hour[4:0] == 5'h11) begin
        hour_nx  = {hour[7:6], ~hour[5], 5'h12};
        day_wrap = hour[5];
      end else if (hour[4:0] == 5'h12) begin
        hour_nx = {hour[7:5], 5'h01};
      end
    end else if (hour[5:0] == 6'h23) begin
      hour_nx  = {hour[7:6], 6'h00};
      day_wrap = 1'b1;
    end
  end

  always_comb begin
    case (month[4:0])
      5'h02:                      last_day = leap ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      tick_1hz <= 1'b0;
      sec      <= 8'h00;
      min      <= 8'h00;
      hour     <= 8'h00;
      dow      <= 8'h01;
      date     <= 8'h01;
      month    <= 8'h01;
      year     <= 8'h00;
    end else begin
      if (sec_wr)
        cnt <= '0;
      else if (tick_32k)
        cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      tick_1hz <= step;
      if (step) begin
        sec <= c_min ? 8'h00 : bcd_inc(sec);
        if (c_min)  min  <= c_hour ? 8'h00 : bcd_inc(min);
        if (c_hour) hour <= hour_nx;
        if (c_day) begin
          dow  <= (dow == 8'h07) ? 8'h01 : dow + 8'd1;
          date <= (date == last_day) ? 8'h01 : bcd_inc(date);
        end
        if (c_month)
          month <= (month[4:0] == 5'h12) ? {month[7] ^ (year == 8'h99), 7'h01} : bcd_inc(month);
        if (c_year)
          year <= (year == 8'h99) ? 8'h00 : bcd_inc(year);
      end
      if (wr_en) begin
        case (wr_addr)
          3'd0: sec   <= wr_data;
          3'd1: min   <= wr_data;
          3'd2: hour  <= wr_data;
          3'd3: dow   <= wr_data;
          3'd4: date  <= wr_data;
          3'd5: month <= wr_data;
          3'd6: year  <= wr_data;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/bcd_calendar_clock_chk.sv
module bcd_calendar_clock_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [2:0] wr_addr,
  input logic [7:0] sec,
  input logic [7:0] min,
  input logic [7:0] hour,
  input logic [7:0] dow,
  input logic [7:0] month,
  input logic [7:0] year,
  input logic       tick_1hz,
  input logic       sq_1hz
);
  a_r1_sec_range: assert property (@(posedge clk) disable iff (!rst_n)
    tick_1hz |-> (sec[3:0] <= 4'd9 && sec <= 8'h59));

  a_r1_min_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_1hz && !$past(wr_en)) |-> $stable(min));

  a_r3_hour12_range: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1hz && hour[6]) |-> (hour[4:0] >= 5'h01 && hour[4:0] <= 5'h12 && hour[3:0] <= 4'd9));

  a_r4_dow_range: assert property (@(posedge clk) disable iff (!rst_n)
    tick_1hz |-> (dow >= 8'h01 && dow <= 8'h07));

  a_r6_century_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1hz && !$past(wr_en) && $past(year) == 8'h99 && year == 8'h00) |-> (month[7] != $past(month[7])));

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tick_1hz |=> !tick_1hz);

  a_r8_sec_write_restart: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && wr_addr == 3'd0) |-> (!tick_1hz && !sq_1hz));
endmodule

bind bcd_calendar_clock bcd_calendar_clock_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .sec(sec), .min(min), .hour(hour), .dow(dow), .month(month), .year(year),
  .tick_1hz(tick_1hz), .sq_1hz(sq_1hz)
);

// File: tb/bcd_calendar_clock_bench.sv
module bcd_calendar_clock_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_T = 4;
  localparam int NV = 19;

  // {sec,min,hour,dow,date,month,year} loaded, then expected after one update
  localparam logic [111:0] VEC [NV] = '{
    {56'h00_00_00_01_01_01_00, 56'h01_00_00_01_01_01_00},
    {56'h59_09_05_03_15_06_24, 56'h00_10_05_03_15_06_24},
    {56'h59_59_09_02_10_03_25, 56'h00_00_10_02_10_03_25},
    {56'h59_59_23_07_31_01_25, 56'h00_00_00_01_01_02_25},
    {56'h59_59_23_02_28_02_23, 56'h00_00_00_03_01_03_23},
    {56'h59_59_23_02_28_02_24, 56'h00_00_00_03_29_02_24},
    {56'h59_59_23_04_29_02_24, 56'h00_00_00_05_01_03_24},
    {56'h59_59_23_04_30_04_25, 56'h00_00_00_05_01_05_25},
    {56'h59_59_23_04_30_05_25, 56'h00_00_00_05_31_05_25},
    {56'h59_59_23_05_31_12_99, 56'h00_00_00_06_01_81_00},
    {56'h59_59_23_05_31_92_99, 56'h00_00_00_06_01_01_00},
    {56'h59_59_51_01_10_07_25, 56'h00_00_72_01_10_07_25},
    {56'h59_59_72_01_10_07_25, 56'h00_00_61_01_10_07_25},
    {56'h59_59_71_03_10_07_25, 56'h00_00_52_04_11_07_25},
    {56'h59_59_52_04_11_07_25, 56'h00_00_41_04_11_07_25},
    {56'h59_59_23_01_28_02_00, 56'h00_00_00_02_29_02_00},
    {56'h59_59_23_02_30_09_25, 56'h00_00_00_03_01_10_25},
    {56'h59_59_23_02_28_02_12, 56'h00_00_00_03_29_02_12},
    {56'h59_59_19_02_28_02_12, 56'h00_00_20_02_28_02_12}
  };
  localparam string TAG [NV] = '{"R1", "R1", "R1", "R2", "R5", "R5", "R5", "R5", "R5",
                                 "R6", "R6", "R3", "R3", "R3", "R3", "R5", "R5", "R5", "R2"};

  logic clk = 1'b0, rst_n = 1'b0, tick_32k = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] sec, min, hour, dow, date, month, year;
  logic tick_1hz, sq_1hz;
  int checks = 0, fails = 0, ticks = 0;

  bcd_calendar_clock #(.DIV(DIV_T)) u_bcd_calendar_clock (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sec(sec), .min(min), .hour(hour), .dow(dow), .date(date),
    .month(month), .year(year), .tick_1hz(tick_1hz), .sq_1hz(sq_1hz));

  wire [55:0] now = {sec, min, hour, dow, date, month, year};

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(negedge clk) if (tick_1hz) ticks++;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic load(input logic [55:0] t);
    wr(3'd1, t[47:40]); wr(3'd2, t[39:32]); wr(3'd3, t[31:24]);
    wr(3'd4, t[23:16]); wr(3'd5, t[15:8]);  wr(3'd6, t[7:0]);
    wr(3'd0, t[55:48]);
  endtask

  task automatic enables(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); tick_32k = 1'b1; end
    @(negedge clk); tick_32k = 1'b0;
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    int t0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset fields", {8'h0, now}, {8'h0, 56'h00_00_00_01_01_01_00});
    chk("R10 reset strobes", {62'h0, tick_1hz, sq_1hz}, 64'h0);

    for (int v = 0; v < NV; v++) begin
      load(VEC[v][111:56]);
      t0 = ticks;
      enables(DIV_T);
      chk(TAG[v], {8'h0, now}, {8'h0, VEC[v][55:0]});
      #1;
      chk("R7 one tick per update", 64'(ticks - t0), 64'd1);
    end

    load(56'h30_20_10_02_05_05_25);
    t0 = ticks;
    repeat (20) @(negedge clk);
    #1;
    chk("R7 idle fields", {8'h0, now}, {8'h0, 56'h30_20_10_02_05_05_25});
    chk("R7 idle ticks", 64'(ticks - t0), 64'd0);

    enables(2);
    wr(3'd0, 8'h20);
    chk("R8 sq low after seconds write", {63'h0, sq_1hz}, 64'd0);
    t0 = ticks;
    enables(2);
    chk("R8 sq high at half", {63'h0, sq_1hz}, 64'd1);
    enables(1);
    #1;
    chk("R8 no tick before full count", 64'(ticks - t0), 64'd0);
    chk("R8 seconds held", {56'h0, sec}, {56'h0, 8'h20});
    enables(1);
    #1;
    chk("R8 tick after full count", 64'(ticks - t0), 64'd1);
    chk("R8 seconds advanced", {56'h0, sec}, {56'h0, 8'h21});

    load(56'h59_10_05_03_15_06_24);
    for (int i = 0; i < DIV_T - 1; i++) begin @(negedge clk); tick_32k = 1'b1; end
    @(negedge clk);
    tick_32k = 1'b1; wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h30;
    @(negedge clk);
    tick_32k = 1'b0; wr_en = 1'b0;
    chk("R9 write overrides same-cycle update", {8'h0, now}, {8'h0, 56'h00_30_05_03_15_06_24});
    chk("R9 tick still pulses", {63'h0, tick_1hz}, 64'd1);

    wr(3'd4, 8'h27);
    chk("R9 date write stored", {56'h0, date}, {56'h0, 8'h27});

    summary();
  end
endmodule